// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is the slave side of a four-wire serial link through which a host reads and writes a small bank of byte-wide registers in a sensor. A transaction opens with chip select going low and closes when it returns high. The first byte on the link is a command. It holds a direction bit, an address-advance flag and a six-bit register address. One or more data bytes then move between the host and the register bank. With the advance flag set, every data byte goes to the next address. With the flag clear, every data byte goes to the same register.

The bank holds a fixed identity byte, six read-only sample bytes and one status byte, both fed from the sensing side of the chip, and six read/write configuration bytes that drive the rest of the chip. One configuration bit moves read data from the dedicated output pin onto the shared input pin, for hosts that use a single bidirectional data line.

The block runs entirely on a fast system clock. Chip select, the serial clock and the data input each pass through a synchronizer, and serial clock edges are found by comparing successive synchronized samples.

Top module: `spi_regbank_slave`

## Requirements
- R1: While reset is asserted, every configuration byte reads as 0x00 on `cfg_o`, and neither `sdo_oe` nor `sdio_oe` is high.
- R2: Address 0x00 always reads 0xDA. A write to address 0x00 changes no state.
- R3: The command byte is sent MSb first. Bit 7 is the direction (1 = read, 0 = write), bit 6 is the advance flag, and bits 5..0 are the address. A write of one data byte (16 clock pulses) to a configuration address 0x0B..0x10 updates byte (address − 0x0B) of `cfg_o`, and a later read returns the written value MSb first.
- R4: When the advance flag is 1, successive data bytes of one transaction go to consecutive addresses, for both writes and reads.
- R5: When the advance flag is 0, every data byte of one transaction uses the command address. On a write, the last byte is the one that stays.
- R6: Addresses 0x01..0x06 return byte (address − 1) of `sample_i`, where byte 0 is bits 7..0. Address 0x0A returns `status_i`.
- R7: Reads of 0x07..0x09 and of 0x11..0x3F return 0x00. Writes to any address outside 0x0B..0x10 leave `cfg_o` and all read values unchanged.
- R8: No data output enable is high while chip select is high or during the command byte. On a read, exactly one enable is high from the start of data bit 8 until the transaction ends.
- R9: Bit 0 of configuration byte 0x0B selects where read data goes: 0 drives `sdo_o` with `sdo_oe`, and 1 drives `sdio_o` with `sdio_oe`.
- R10: When chip select rises before a byte is complete, that partial byte is discarded. The next transaction starts again with a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdio_i | input | 1 | Serial data input (the shared data pin) |
| sdio_o | output | 1 | Read data driven onto the shared pin in single-line mode |
| sdio_oe | output | 1 | Output enable for the shared pin |
| sdo_o | output | 1 | Read data on the dedicated output pin |
| sdo_oe | output | 1 | Output enable for the dedicated output pin |
| sample_i | input | 48 | Six sample bytes, byte 0 at address 0x01 |
| status_i | input | 8 | Status byte, read at address 0x0A |
| cfg_o | output | 48 | Six configuration bytes, byte 0 at address 0x0B |

## Verification
The bench uses the default parameters: a six-bit address, six sample bytes, six configuration bytes and two synchronizer stages. The serial clock runs at sixteen system clocks per bit. At these values every address class can be reached: identity, sample, status, gap, configuration and the space above the bank. An advancing burst covers the whole configuration range in one transaction, and the synchronizer delay sits well inside half a serial clock period, so data can be sampled at each rising edge. Transfers cut off mid-byte and reads in both pin modes complete the set.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] byte_t;
  localparam int CMD_DIR_BIT = 7;
  localparam int CMD_INC_BIT = 6;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= RST_VAL;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_rb_engine.sv
module spi_rb_engine
  import spi_rb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_bit,
  input  byte_t             rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output byte_t             wr_data,
  output logic              out_bit,
  output logic              out_en
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic [BIT_CNT_W-1:0] bcnt_q, bcnt_d;
  logic                 data_ph_q, data_ph_d;
  logic                 rd_mode_q, rd_mode_d;
  logic                 adv_q, adv_d;
  logic [ADDR_W-1:0]    ptr_q, ptr_d;
  byte_t                rx_q, rx_d;
  byte_t                tx_q, tx_d;
  logic                 obit_q, obit_d;
  logic                 oen_q, oen_d;

  byte_t             rx_byte;
  logic              byte_done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [ADDR_W-1:0] ptr_adv;

  assign rx_byte   = {rx_q[BYTE_W-2:0], sdi_bit};
  assign byte_done = cs_act && sclk_rise && (bcnt_q == LAST_BIT);
  assign cmd_addr  = rx_byte[ADDR_W-1:0];
  assign ptr_adv   = adv_q ? ptr_q + ADDR_W'(1) : ptr_q;
  assign rd_addr   = data_ph_q ? ptr_adv : cmd_addr;

  assign wr_en   = byte_done && data_ph_q && !rd_mode_q;
  assign wr_addr = ptr_q;
  assign wr_data = rx_byte;

  always_comb begin
    bcnt_d    = bcnt_q;
    data_ph_d = data_ph_q;
    rd_mode_d = rd_mode_q;
    adv_d     = adv_q;
    ptr_d     = ptr_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    obit_d    = obit_q;
    oen_d     = oen_q;
    if (!cs_act) begin
      bcnt_d    = '0;
      data_ph_d = 1'b0;
      rd_mode_d = 1'b0;
      adv_d     = 1'b0;
      oen_d     = 1'b0;
      obit_d    = 1'b0;
    end else if (sclk_rise) begin
      rx_d   = rx_byte;
      bcnt_d = bcnt_q + BIT_CNT_W'(1);
      if (byte_done) begin
        tx_d = rd_data;
        if (!data_ph_q) begin
          data_ph_d = 1'b1;
          rd_mode_d = rx_byte[CMD_DIR_BIT];
          adv_d     = rx_byte[CMD_INC_BIT];
          ptr_d     = cmd_addr;
        end else begin
          ptr_d = ptr_adv;
        end
      end
    end else if (sclk_fall && data_ph_q && rd_mode_q) begin
      obit_d = tx_q[BYTE_W-1];
      tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
      oen_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q    <= '0;
      data_ph_q <= 1'b0;
      rd_mode_q <= 1'b0;
      adv_q     <= 1'b0;
      ptr_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      obit_q    <= 1'b0;
      oen_q     <= 1'b0;
    end else begin
      bcnt_q    <= bcnt_d;
      data_ph_q <= data_ph_d;
      rd_mode_q <= rd_mode_d;
      adv_q     <= adv_d;
      ptr_q     <= ptr_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      obit_q    <= obit_d;
      oen_q     <= oen_d;
    end
  end

  assign out_bit = obit_q;
  assign out_en  = oen_q;
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile
  import spi_rb_pkg::*;
#(
  parameter int    ADDR_W       = 6,
  parameter int    SAMPLE_BYTES = 6,
  parameter int    NUM_RW       = 6,
  parameter int    STATUS_ADDR  = 10,
  parameter int    RW_BASE      = 11,
  parameter byte_t ID_VALUE     = 8'hDA
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  byte_t                        wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [SAMPLE_BYTES*BYTE_W-1:0] sample_i,
  input  byte_t                        status_i,
  output byte_t                        rd_data,
  output logic [NUM_RW*BYTE_W-1:0]     cfg_o
);
  byte_t cfg_q [NUM_RW];
  byte_t cfg_d [NUM_RW];

  for (genvar k = 0; k < NUM_RW; k++) begin : g_cfg
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(RW_BASE + k));
    assign cfg_d[k] = hit ? wr_data : cfg_q[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[k] <= '0;
      else        cfg_q[k] <= cfg_d[k];
    end
    assign cfg_o[k*BYTE_W +: BYTE_W] = cfg_q[k];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = ID_VALUE;
    if (rd_addr == ADDR_W'(STATUS_ADDR)) rd_data = status_i;
    for (int k = 0; k < SAMPLE_BYTES; k++) begin
      if (rd_addr == ADDR_W'(k + 1)) rd_data = sample_i[k*BYTE_W +: BYTE_W];
    end
    for (int k = 0; k < NUM_RW; k++) begin
      if (rd_addr == ADDR_W'(RW_BASE + k)) rd_data = cfg_q[k];
    end
  end
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_rb_pkg::*;
#(
  parameter int    ADDR_W       = 6,
  parameter int    SAMPLE_BYTES = 6,
  parameter int    NUM_RW       = 6,
  parameter int    STATUS_ADDR  = 10,
  parameter int    RW_BASE      = 11,
  parameter int    MODE_BIT     = 0,
  parameter int    SYNC_STAGES  = 2,
  parameter byte_t ID_VALUE     = 8'hDA
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cs_n,
  input  logic                           sclk,
  input  logic                           sdio_i,
  output logic                           sdio_o,
  output logic                           sdio_oe,
  output logic                           sdo_o,
  output logic                           sdo_oe,
  input  logic [SAMPLE_BYTES*BYTE_W-1:0] sample_i,
  input  logic [BYTE_W-1:0]              status_i,
  output logic [NUM_RW*BYTE_W-1:0]       cfg_o
);
  logic [2:0] sync_q;
  logic       cs_n_s, sclk_s, sdi_s;
  logic       sclk_prev_q;
  logic       cs_act, sclk_rise, sclk_fall;

  spi_rb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdio_i}), .q(sync_q)
  );
  assign {cs_n_s, sclk_s, sdi_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b1;
    else        sclk_prev_q <= sclk_s;
  end

  assign cs_act    = !cs_n_s;
  assign sclk_rise = sclk_s && !sclk_prev_q;
  assign sclk_fall = !sclk_s && sclk_prev_q;

  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              wr_en, out_bit, out_en;
  byte_t             rd_data, wr_data;

  spi_rb_engine #(.ADDR_W(ADDR_W)) i_engine (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .sdi_bit(sdi_s), .rd_data(rd_data),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_bit(out_bit), .out_en(out_en)
  );

  spi_rb_regfile #(
    .ADDR_W(ADDR_W), .SAMPLE_BYTES(SAMPLE_BYTES), .NUM_RW(NUM_RW),
    .STATUS_ADDR(STATUS_ADDR), .RW_BASE(RW_BASE), .ID_VALUE(ID_VALUE)
  ) i_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .sample_i(sample_i),
    .status_i(status_i), .rd_data(rd_data), .cfg_o(cfg_o)
  );

  logic one_line;
  assign one_line = cfg_o[MODE_BIT];
  assign sdo_o    = out_bit;
  assign sdio_o   = out_bit;
  assign sdo_oe   = out_en && !one_line;
  assign sdio_oe  = out_en && one_line;
endmodule

// File: rtl/spi_regbank_checker.sv
module spi_regbank_checker #(
  parameter int CFG_W    = 48,
  parameter int MODE_BIT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sdo_oe,
  input logic             sdio_oe,
  input logic [CFG_W-1:0] cfg_o
);
  logic [2:0] idle_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idle_cnt <= '0;
    else if (!cs_n)      idle_cnt <= '0;
    else if (idle_cnt != 3'd7) idle_cnt <= idle_cnt + 3'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (cfg_o == '0 && !sdo_oe && !sdio_oe));

  assert_one_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_oe && sdio_oe));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt >= 3'd4) |-> (!sdo_oe && !sdio_oe));

  assert_idle_cfg_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt >= 3'd4) |-> $stable(cfg_o));

  assert_pin_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe |-> cfg_o[MODE_BIT]) and (sdo_oe |-> !cfg_o[MODE_BIT]));
endmodule

bind spi_regbank_slave spi_regbank_checker #(
  .CFG_W(NUM_RW*8), .MODE_BIT(MODE_BIT)
) i_checker (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe),
  .sdio_oe(sdio_oe), .cfg_o(cfg_o)
);

// File: tb/test_spi_regbank_slave.sv
module test_spi_regbank_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [47:0] SAMPLE_V = 48'hC6B5A4938271;
  localparam logic [7:0]  STATUS_V = 8'h3C;

  logic clk, rst_n, cs_n, sclk, sdio_i;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [47:0] sample_i;
  logic [7:0]  status_i;
  logic [47:0] cfg_o;

  spi_regbank_slave i_spi_regbank_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .sample_i(sample_i), .status_i(status_i), .cfg_o(cfg_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mosi [16];
  logic [7:0] miso [16];
  bit cmd_drv;
  int sdo_cnt, sdio_cnt;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_run(input int nbits);
    cmd_drv = 0; sdo_cnt = 0; sdio_cnt = 0;
    cs_n = 1'b0;
    wait_sys(HALF);
    for (int b = 0; b < nbits; b++) begin
      sclk = 1'b0;
      sdio_i = mosi[b/8][7 - b%8];
      wait_sys(HALF);
      if (b < 8 && (sdo_oe || sdio_oe)) cmd_drv = 1;
      if (b >= 8) begin
        if (sdo_oe) sdo_cnt++;
        if (sdio_oe) sdio_cnt++;
      end
      miso[b/8][7 - b%8] = sdo_oe ? sdo_o : (sdio_oe ? sdio_o : 1'b0);
      sclk = 1'b1;
      wait_sys(HALF);
    end
    wait_sys(HALF);
    cs_n = 1'b1;
    wait_sys(4*HALF);
  endtask

  task automatic spi_wr(input logic [5:0] addr, input bit inc, input int n);
    mosi[0] = {1'b0, inc, addr};
    spi_run(8 + 8*n);
  endtask

  task automatic spi_rd(input logic [5:0] addr, input bit inc, input int n);
    mosi[0] = {1'b1, inc, addr};
    for (int i = 1; i <= n; i++) mosi[i] = 8'h00;
    spi_run(8 + 8*n);
  endtask

  task automatic t_reset;
    chk("R1 cfg after reset", cfg_o, 48'h0);
    chk("R1 sdo_oe idle", sdo_oe, 1'b0);
    chk("R1 sdio_oe idle", sdio_oe, 1'b0);
  endtask

  task automatic t_identity;
    spi_rd(6'h00, 0, 1);
    chk("R2 identity read", miso[1], 8'hDA);
    mosi[1] = 8'h55;
    spi_wr(6'h00, 0, 1);
    chk("R2 identity write ignored cfg", cfg_o, 48'h0);
    spi_rd(6'h00, 0, 1);
    chk("R2 identity after write", miso[1], 8'hDA);
  endtask

  task automatic t_single;
    mosi[1] = 8'hA5;
    spi_wr(6'h0C, 0, 1);
    chk("R3 write lands in cfg byte 1", cfg_o[15:8], 8'hA5);
    chk("R3 other cfg untouched", {cfg_o[47:16], cfg_o[7:0]}, 40'h0);
    spi_rd(6'h0C, 0, 1);
    chk("R3 read back", miso[1], 8'hA5);
    chk("R8 no drive during command", cmd_drv, 1'b0);
    chk("R8 sdo driven every data bit", sdo_cnt, 8);
    chk("R8 released after cs", sdo_oe | sdio_oe, 1'b0);
  endtask

  task automatic t_burst_inc;
    mosi[1] = 8'h20; mosi[2] = 8'h42; mosi[3] = 8'h64;
    mosi[4] = 8'h86; mosi[5] = 8'hA8; mosi[6] = 8'hCA;
    spi_wr(6'h0B, 1, 6);
    chk("R4 burst write advancing", cfg_o, 48'hCAA886644220);
    spi_rd(6'h0B, 1, 6);
    chk("R4 burst read advancing", {miso[6], miso[5], miso[4], miso[3], miso[2], miso[1]},
        48'hCAA886644220);
  endtask

  task automatic t_fixed;
    mosi[1] = 8'h11; mosi[2] = 8'h22; mosi[3] = 8'h33;
    spi_wr(6'h0E, 0, 3);
    chk("R5 fixed write last wins", cfg_o, 48'hCAA833644220);
    spi_rd(6'h0F, 0, 3);
    chk("R5 fixed read repeats", {miso[3], miso[2], miso[1]}, 24'hA8A8A8);
  endtask

  task automatic t_samples;
    spi_rd(6'h01, 1, 6);
    chk("R6 sample bytes", {miso[6], miso[5], miso[4], miso[3], miso[2], miso[1]}, SAMPLE_V);
    spi_rd(6'h0A, 0, 1);
    chk("R6 status byte", miso[1], STATUS_V);
  endtask

  task automatic t_unmapped;
    spi_rd(6'h08, 0, 1);
    chk("R7 gap reads zero", miso[1], 8'h00);
    spi_rd(6'h2A, 0, 1);
    chk("R7 high address reads zero", miso[1], 8'h00);
    mosi[1] = 8'hFF;
    spi_wr(6'h03, 0, 1);
    mosi[1] = 8'hEE;
    spi_wr(6'h30, 0, 1);
    chk("R7 ignored writes keep cfg", cfg_o, 48'hCAA833644220);
    spi_rd(6'h03, 0, 1);
    chk("R7 sample unchanged", miso[1], 8'h93);
    spi_rd(6'h30, 0, 1);
    chk("R7 written high address still zero", miso[1], 8'h00);
  endtask

  task automatic t_one_line;
    mosi[1] = 8'h01;
    spi_wr(6'h0B, 0, 1);
    chk("R9 mode bit set", cfg_o[0], 1'b1);
    spi_rd(6'h0D, 0, 1);
    chk("R9 data on shared pin", miso[1], 8'h64);
    chk("R9 shared pin enables", sdio_cnt, 8);
    chk("R9 dedicated pin silent", sdo_cnt, 0);
    chk("R8 no drive in command single-line", cmd_drv, 1'b0);
    mosi[1] = 8'h00;
    spi_wr(6'h0B, 0, 1);
    spi_rd(6'h0D, 0, 1);
    chk("R9 back on dedicated pin", sdo_cnt, 8);
    chk("R9 shared pin silent again", sdio_cnt, 0);
    chk("R9 data after restore", miso[1], 8'h64);
  endtask

  task automatic t_abort;
    mosi[0] = {1'b0, 1'b0, 6'h0D};
    mosi[1] = 8'hF0;
    spi_run(12);
    chk("R10 partial data byte dropped", cfg_o[23:16], 8'h64);
    mosi[0] = 8'h0D;
    spi_run(5);
    spi_rd(6'h0D, 0, 1);
    chk("R10 fresh command after abort", miso[1], 8'h64);
    mosi[1] = 8'h5A;
    spi_wr(6'h10, 0, 1);
    chk("R10 normal write after abort", cfg_o[47:40], 8'h5A);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1-all actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdio_i = 1'b0;
    sample_i = SAMPLE_V; status_i = STATUS_V;
    wait_sys(5);
    t_reset();
    rst_n = 1'b1;
    wait_sys(5);
    t_identity();
    t_single();
    t_burst_inc();
    t_fixed();
    t_samples();
    t_unmapped();
    t_one_line();
    t_abort();
    finish_run();
  end
endmodule